// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a virtual address into a physical address by walking a two-level translation tree kept in an external, word-addressed memory. The virtual address has three fields: a top index that picks a slot in the first-level table, a middle index that picks a slot in a second-level table, and a page offset that is passed through unchanged. A first-level slot is either empty, which leaves a whole region unmapped, or it points at a second-level table. A second-level slot carries a physical page number with valid, resident and access-permission flags.

A requester presents one address at a time on a valid/ready port and gets back a one-cycle response with either a physical address or a fault code. The walker issues its own reads on a read-request/read-data port and waits for each word, so memory latency may vary. A root register holds the word address of the first-level table of the current context. Software reloads it on a context switch. A reload that arrives during a walk is held back until that walk has finished.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_rd_en is 0, and the root register is 0.
- R2: An accepted request issues exactly one read at address root + va[31:22] (modulo 2^MEM_AW). It then waits for mem_rd_valid, however many cycles that takes, before it issues anything else. mem_rd_en is never high on two cycles in a row.
- R3: If bit 0 (present) of the first-level word is 0, the walk ends with fault code 1 and rsp_pa = 0, after one memory read and no second read.
- R4: If the first-level word is present, the second read goes to (word >> 1) + va[21:12], truncated to MEM_AW bits.
- R5: If bit 0 (valid) or bit 1 (resident) of the second-level word is 0, the response carries fault code 2 and rsp_pa = 0.
- R6: For a valid, resident and permitted second-level word, rsp_fault is 0 and rsp_pa = {word[31:12], va[11:0]}. The walk uses exactly two reads.
- R7: When CHECK_PROT = 1, bit 2 of the second-level word allows reads and bit 3 allows writes. A read with bit 2 clear, or a write with bit 3 clear, gives fault code 3 and rsp_pa = 0. Fault code 2 takes priority over code 3.
- R8: rsp_valid is high for exactly one cycle per walk, and req_ready is high on the next cycle. req_ready is 1 only when no walk is in progress. A request held while busy starts no read and produces no response.
- R9: A root write while the walker is idle takes effect at that clock edge. A request accepted on the same edge walks the new tree.
- R10: A root write during a walk leaves that walk's tree unchanged. It takes effect when the walk ends. If several such writes arrive, the last one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken on this edge |
| req_va | input | L1_BITS+L2_BITS+OFF_BITS | Virtual address to translate |
| req_write | input | 1 | 1 for a store access, 0 for a load |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | PPN_W+OFF_BITS | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 ok, 1 region unmapped, 2 page invalid or not resident, 3 access denied |
| root_wr_en | input | 1 | Load the root register |
| root_wr_data | input | MEM_AW | Word address of the new first-level table |
| mem_rd_en | output | 1 | One-cycle read request |
| mem_rd_addr | output | MEM_AW | Word address of the read |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | DW | Returned table word |

## Verification
The bench builds the walker with MEM_AW = 12 so that two first-level tables and two second-level tables fit in a 4096-word model memory. It keeps the 10/10/12 address split and a 32-bit word, and sets CHECK_PROT = 1. With these values the bench can reach the last slot of both levels (indices 1023) and the all-ones physical address. It also switches between two trees that share one second-level table. The model memory answers with a latency of one to three cycles, which varies per vector, so the waiting states are held for different lengths.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD1,
      ST_WT1,
      ST_RD2,
      ST_WT2,
      ST_RESP
   } walk_st_e;

   typedef enum logic [1:0] {
      FLT_NONE       = 2'd0,
      FLT_L1_ABSENT  = 2'd1,
      FLT_L2_INVALID = 2'd2,
      FLT_PROT       = 2'd3
   } fault_e;

   // flag positions inside table words
   localparam int L1_PRESENT_BIT = 0;
   localparam int L2_VALID_BIT   = 0;
   localparam int L2_RES_BIT     = 1;
   localparam int L2_RD_BIT      = 2;
   localparam int L2_WR_BIT      = 3;
   localparam int L2_FLAG_BITS   = 4;

endpackage

// File: rtl/ptw_root_reg.sv
module ptw_root_reg #(
   parameter int MEM_AW = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idle,
   input  logic              done,
   input  logic              wr_en,
   input  logic [MEM_AW-1:0] wr_data,
   output logic [MEM_AW-1:0] root
);

   logic              pend_q;
   logic [MEM_AW-1:0] pend_val_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         root       <= '0;
         pend_q     <= 1'b0;
         pend_val_q <= '0;
      end else if (idle) begin
         if (wr_en) root <= wr_data;
      end else if (done) begin
         if (wr_en)       root <= wr_data;
         else if (pend_q) root <= pend_val_q;
         pend_q <= 1'b0;
      end else if (wr_en) begin
         pend_q     <= 1'b1;
         pend_val_q <= wr_data;
      end
   end

   // R10
   root_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && !done) |=> $stable(root));

endmodule

// File: rtl/ptw_l2_check.sv
module ptw_l2_check
   import ptw_pkg::*;
#(
   parameter int DW         = 32,
   parameter int PPN_W      = 20,
   parameter int OFF_BITS   = 12,
   parameter bit CHECK_PROT = 1'b1
) (
   input  logic [DW-1:0]             entry,
   input  logic                      is_write,
   input  logic [OFF_BITS-1:0]       offset,
   output fault_e                    fault,
   output logic [PPN_W+OFF_BITS-1:0] pa
);

   localparam int RSV_LO = L2_FLAG_BITS;
   localparam int RSV_HI = DW - PPN_W - 1;

   logic [PPN_W-1:0] ppn;
   logic             prot_bad;
   logic             entry_bad;

   assign ppn       = entry[DW-1 -: PPN_W];
   assign entry_bad = !entry[L2_VALID_BIT] || !entry[L2_RES_BIT];

   generate
      if (CHECK_PROT) begin : g_prot
         assign prot_bad = is_write ? !entry[L2_WR_BIT] : !entry[L2_RD_BIT];
      end else begin : g_noprot
         wire unused_perm = entry[L2_WR_BIT] ^ entry[L2_RD_BIT] ^ is_write;
         assign prot_bad = 1'b0;
      end
      if (RSV_HI >= RSV_LO) begin : g_rsv
         wire unused_rsvd = ^entry[RSV_HI:RSV_LO];
      end
   endgenerate

   always_comb begin
      if (entry_bad)     fault = FLT_L2_INVALID;
      else if (prot_bad) fault = FLT_PROT;
      else               fault = FLT_NONE;
      pa = (fault == FLT_NONE) ? {ppn, offset} : '0;
   end

endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
   import ptw_pkg::*;
#(
   parameter int L1_BITS  = 10,
   parameter int L2_BITS  = 10,
   parameter int OFF_BITS = 12,
   parameter int DW       = 32,
   parameter int MEM_AW   = 30,
   parameter int PA_W     = 32
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              req_valid,
   input  logic [L1_BITS+L2_BITS+OFF_BITS-1:0] req_va,
   input  logic                              req_write,
   output logic                              req_ready,
   input  logic [MEM_AW-1:0]                 root,
   output logic                              mem_rd_en,
   output logic [MEM_AW-1:0]                 mem_rd_addr,
   input  logic                              mem_rd_valid,
   input  logic [DW-1:0]                     mem_rd_data,
   input  fault_e                            chk_fault,
   input  logic [PA_W-1:0]                   chk_pa,
   output logic                              walk_write,
   output logic [OFF_BITS-1:0]               walk_off,
   output logic                              idle,
   output logic                              done,
   output logic                              rsp_valid,
   output logic [PA_W-1:0]                   rsp_pa,
   output logic [1:0]                        rsp_fault
);

   localparam int VA_W  = L1_BITS + L2_BITS + OFF_BITS;
   localparam int L2_LO = OFF_BITS;
   localparam int L1_LO = OFF_BITS + L2_BITS;

   walk_st_e          st_q;
   logic [VA_W-1:0]   va_q;
   logic              wr_q;
   logic [MEM_AW-1:0] l2_base_q;
   fault_e            code_q;
   logic [PA_W-1:0]   pa_q;
   logic [1:0]        rd_cnt_q;

   logic [MEM_AW-1:0] l1_addr;
   logic [MEM_AW-1:0] l2_addr;

   assign l1_addr = root + MEM_AW'(va_q[VA_W-1:L1_LO]);
   assign l2_addr = l2_base_q + MEM_AW'(va_q[L1_LO-1:L2_LO]);

   assign idle        = (st_q == ST_IDLE);
   assign done        = (st_q == ST_RESP);
   assign req_ready   = idle;
   assign mem_rd_en   = (st_q == ST_RD1) || (st_q == ST_RD2);
   assign mem_rd_addr = (st_q == ST_RD2) ? l2_addr : l1_addr;
   assign walk_write  = wr_q;
   assign walk_off    = va_q[OFF_BITS-1:0];
   assign rsp_valid   = done;
   assign rsp_pa      = pa_q;
   assign rsp_fault   = code_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         va_q      <= '0;
         wr_q      <= 1'b0;
         l2_base_q <= '0;
         code_q    <= FLT_NONE;
         pa_q      <= '0;
         rd_cnt_q  <= '0;
      end else begin
         if (mem_rd_en) rd_cnt_q <= rd_cnt_q + 2'd1;
         unique case (st_q)
            ST_IDLE: begin
               rd_cnt_q <= '0;
               if (req_valid) begin
                  va_q <= req_va;
                  wr_q <= req_write;
                  st_q <= ST_RD1;
               end
            end
            ST_RD1: st_q <= ST_WT1;
            ST_WT1: if (mem_rd_valid) begin
               if (mem_rd_data[L1_PRESENT_BIT]) begin
                  l2_base_q <= MEM_AW'(mem_rd_data >> 1);
                  st_q      <= ST_RD2;
               end else begin
                  code_q <= FLT_L1_ABSENT;
                  pa_q   <= '0;
                  st_q   <= ST_RESP;
               end
            end
            ST_RD2: st_q <= ST_WT2;
            ST_WT2: if (mem_rd_valid) begin
               code_q <= chk_fault;
               pa_q   <= chk_pa;
               st_q   <= ST_RESP;
            end
            ST_RESP: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R2
   single_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

   // R3
   l1_one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == FLT_L1_ABSENT) |-> (rd_cnt_q == 2'd1));

   // R6
   two_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != FLT_L1_ABSENT) |-> (rd_cnt_q == 2'd2));

   // R5
   fault_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_pa == '0));

   // R8
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && req_ready));

   // R8
   no_rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_rd_en);

endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import ptw_pkg::*;
#(
   parameter int L1_BITS    = 10,
   parameter int L2_BITS    = 10,
   parameter int OFF_BITS   = 12,
   parameter int DW         = 32,
   parameter int PPN_W      = 20,
   parameter int MEM_AW     = 30,
   parameter bit CHECK_PROT = 1'b1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                req_valid,
   output logic                                req_ready,
   input  logic [L1_BITS+L2_BITS+OFF_BITS-1:0] req_va,
   input  logic                                req_write,
   output logic                                rsp_valid,
   output logic [PPN_W+OFF_BITS-1:0]           rsp_pa,
   output logic [1:0]                          rsp_fault,
   input  logic                                root_wr_en,
   input  logic [MEM_AW-1:0]                   root_wr_data,
   output logic                                mem_rd_en,
   output logic [MEM_AW-1:0]                   mem_rd_addr,
   input  logic                                mem_rd_valid,
   input  logic [DW-1:0]                       mem_rd_data
);

   localparam int PA_W = PPN_W + OFF_BITS;

   initial begin
      assert (L1_BITS >= 1 && L2_BITS >= 1 && OFF_BITS >= 1)
         else $error("index and offset fields must be non-empty");
      assert (DW - PPN_W >= L2_FLAG_BITS)
         else $error("page number overlaps the flag bits");
      assert (MEM_AW >= 1 && MEM_AW < DW)
         else $error("table pointer does not fit in a word");
   end

   logic [MEM_AW-1:0]   root;
   logic                idle;
   logic                done;
   logic                walk_write;
   logic [OFF_BITS-1:0] walk_off;
   fault_e              chk_fault;
   logic [PA_W-1:0]     chk_pa;

   ptw_root_reg #(.MEM_AW(MEM_AW)) u_root (
      .clk     (clk),
      .rst_n   (rst_n),
      .idle    (idle),
      .done    (done),
      .wr_en   (root_wr_en),
      .wr_data (root_wr_data),
      .root    (root)
   );

   ptw_l2_check #(
      .DW(DW), .PPN_W(PPN_W), .OFF_BITS(OFF_BITS), .CHECK_PROT(CHECK_PROT)
   ) u_chk (
      .entry    (mem_rd_data),
      .is_write (walk_write),
      .offset   (walk_off),
      .fault    (chk_fault),
      .pa       (chk_pa)
   );

   ptw_fsm #(
      .L1_BITS(L1_BITS), .L2_BITS(L2_BITS), .OFF_BITS(OFF_BITS),
      .DW(DW), .MEM_AW(MEM_AW), .PA_W(PA_W)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_va       (req_va),
      .req_write    (req_write),
      .req_ready    (req_ready),
      .root         (root),
      .mem_rd_en    (mem_rd_en),
      .mem_rd_addr  (mem_rd_addr),
      .mem_rd_valid (mem_rd_valid),
      .mem_rd_data  (mem_rd_data),
      .chk_fault    (chk_fault),
      .chk_pa       (chk_pa),
      .walk_write   (walk_write),
      .walk_off     (walk_off),
      .idle         (idle),
      .done         (done),
      .rsp_valid    (rsp_valid),
      .rsp_pa       (rsp_pa),
      .rsp_fault    (rsp_fault)
   );

endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;

   localparam int AW = 12;

   typedef struct packed {
      logic [31:0] va;
      logic        wr;
      logic [1:0]  code;
      logic [31:0] pa;
      logic [1:0]  nrd;
   } vec_t;

   localparam vec_t VEC [0:11] = '{
      '{32'h0040_5234, 1'b0, 2'd0, 32'h1234_5234, 2'd2},
      '{32'h0040_5ABC, 1'b1, 2'd0, 32'h1234_5ABC, 2'd2},
      '{32'h0040_6010, 1'b0, 2'd0, 32'hABCD_E010, 2'd2},
      '{32'h0040_6010, 1'b1, 2'd3, 32'h0,         2'd2},
      '{32'h0040_7000, 1'b0, 2'd2, 32'h0,         2'd2},
      '{32'h0040_7000, 1'b1, 2'd2, 32'h0,         2'd2},
      '{32'h0040_8FFF, 1'b0, 2'd2, 32'h0,         2'd2},
      '{32'h0040_9001, 1'b0, 2'd3, 32'h0,         2'd2},
      '{32'h0040_9001, 1'b1, 2'd0, 32'h0004_2001, 2'd2},
      '{32'h00BF_FFFF, 1'b0, 2'd0, 32'hFFFF_FFFF, 2'd2},
      '{32'h0000_0000, 1'b0, 2'd1, 32'h0,         2'd1},
      '{32'hFFC0_0123, 1'b1, 2'd1, 32'h0,         2'd1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [31:0]   req_va = '0;
   logic          req_write = 1'b0;
   logic          rsp_valid;
   logic [31:0]   rsp_pa;
   logic [1:0]    rsp_fault;
   logic          root_wr_en = 1'b0;
   logic [AW-1:0] root_wr_data = '0;
   logic          mem_rd_en;
   logic [AW-1:0] mem_rd_addr;
   logic          mem_rd_valid = 1'b0;
   logic [31:0]   mem_rd_data = '0;

   pt_walker #(.MEM_AW(AW), .CHECK_PROT(1'b1)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_va(req_va), .req_write(req_write),
      .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
      .root_wr_en(root_wr_en), .root_wr_data(root_wr_data),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
   );

   always #2.5 clk = ~clk;

   // model memory
   logic [31:0]   mem [0:4095];
   int            lat = 1;
   int            nreads = 0;
   logic [AW-1:0] rd_addr [0:3];
   bit            pend = 1'b0;
   int            cnt = 0;
   logic [AW-1:0] paddr = '0;

   always @(negedge clk) begin
      mem_rd_valid = 1'b0;
      if (pend) begin
         if (cnt == 0) begin
            mem_rd_valid = 1'b1;
            mem_rd_data  = mem[paddr];
            pend = 1'b0;
         end else cnt = cnt - 1;
      end
      if (mem_rd_en) begin
         pend  = 1'b1;
         cnt   = lat - 1;
         paddr = mem_rd_addr;
         if (nreads < 4) rd_addr[nreads] = mem_rd_addr;
         nreads = nreads + 1;
      end
   end

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
         finish_run();
      end
   end

   logic [1:0]  got_code;
   logic [31:0] got_pa;

   // one walk; optional same-cycle root write, mid-walk root writes, held request
   task automatic walk(input logic [31:0] va, input logic wr,
                       input bit same_root, input bit mid_root,
                       input logic [AW-1:0] rval, input bit hold);
      int t;
      @(negedge clk);
      nreads     = 0;
      req_valid  = 1'b1;
      req_va     = va;
      req_write  = wr;
      root_wr_en = same_root;
      root_wr_data = rval;
      check("R8", "ready before request", {31'd0, req_ready}, 32'd1);
      @(negedge clk);
      root_wr_en = 1'b0;
      if (hold) begin
         req_va    = 32'hFFC0_0123;
         req_write = 1'b1;
      end else req_valid = 1'b0;
      t = 0;
      while (!rsp_valid && t < 100) begin
         if (mid_root && t == 0) begin root_wr_en = 1'b1; root_wr_data = 12'h123; end
         else if (mid_root && t == 1) begin root_wr_en = 1'b1; root_wr_data = rval; end
         else root_wr_en = 1'b0;
         @(negedge clk);
         t++;
      end
      root_wr_en = 1'b0;
      if (!rsp_valid) begin
         fails++;
         $display("FAIL R2 response: actual none expected within 100 cycles");
      end
      got_code  = rsp_fault;
      got_pa    = rsp_pa;
      req_valid = 1'b0;
      @(negedge clk);
      check("R8", "strobe width", {31'd0, rsp_valid}, 32'd0);
      check("R8", "ready after response", {31'd0, req_ready}, 32'd1);
   endtask

   task automatic walk_check(input vec_t v, input logic [AW-1:0] root_now);
      logic [AW-1:0] a1;
      logic [AW-1:0] a2;
      string rq;
      a1 = root_now + AW'(v.va[31:22]);
      a2 = AW'(mem[a1] >> 1) + AW'(v.va[21:12]);
      rq = (v.code == 2'd0) ? "R6" : (v.code == 2'd1) ? "R3" :
           (v.code == 2'd2) ? "R5" : "R7";
      check(rq, "fault code", {30'd0, got_code}, {30'd0, v.code});
      check(rq, "physical address", got_pa, v.pa);
      check(rq, "read count", nreads, {30'd0, v.nrd});
      check("R2", "first read address", {20'd0, rd_addr[0]}, {20'd0, a1});
      if (v.nrd == 2'd2)
         check("R4", "second read address", {20'd0, rd_addr[1]}, {20'd0, a2});
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = '0;
      // tree A at 0x000
      mem[12'h001] = 32'h0000_1001;
      mem[12'h002] = 32'h0000_1801;
      // tree B at 0x400
      mem[12'h401] = 32'h0000_1801;
      // second-level tables at 0x800 and 0xC00
      mem[12'h805] = 32'h1234_500F;
      mem[12'h806] = 32'hABCD_E007;
      mem[12'h807] = 32'h1111_100D;
      mem[12'h808] = 32'h0000_0000;
      mem[12'h809] = 32'h0004_200B;
      mem[12'hFFF] = 32'hFFFF_F00F;
      mem[12'hC05] = 32'h5555_500F;

      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "req_ready in reset", {31'd0, req_ready}, 32'd1);
      check("R1", "rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
      check("R1", "mem_rd_en in reset", {31'd0, mem_rd_en}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", "idle after reset", {30'd0, req_ready, mem_rd_en}, 32'd2);

      // vector table, root left at its reset value 0 (R1)
      for (int i = 0; i < 12; i++) begin
         lat = 1 + (i % 3);
         walk(VEC[i].va, VEC[i].wr, 1'b0, 1'b0, '0, 1'b0);
         walk_check(VEC[i], 12'h000);
      end

      // R9: root write on the accepting edge
      lat = 2;
      walk(32'h0040_5234, 1'b0, 1'b1, 1'b0, 12'h400, 1'b0);
      check("R9", "new tree result", got_pa, 32'h5555_5234);
      check("R9", "new tree first read", {20'd0, rd_addr[0]}, 32'h401);

      // back to tree A while idle
      @(negedge clk);
      root_wr_en = 1'b1; root_wr_data = 12'h000;
      @(negedge clk);
      root_wr_en = 1'b0;

      // R10: two writes mid-walk, last one wins after the walk
      lat = 3;
      walk(32'h0040_5234, 1'b0, 1'b0, 1'b1, 12'h400, 1'b0);
      check("R10", "current walk keeps tree", got_pa, 32'h1234_5234);
      check("R10", "current walk first read", {20'd0, rd_addr[0]}, 32'h001);
      lat = 1;
      walk(32'h0040_5234, 1'b0, 1'b0, 1'b0, '0, 1'b0);
      check("R10", "deferred root used", got_pa, 32'h5555_5234);
      check("R10", "deferred root address", {20'd0, rd_addr[0]}, 32'h401);

      // R8: request held high during a busy walk is ignored
      lat = 3;
      walk(32'h0040_5234, 1'b0, 1'b0, 1'b0, '0, 1'b1);
      check("R8", "held request walk result", got_pa, 32'h5555_5234);
      check("R8", "held request reads", nreads, 32'd2);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         if (rsp_valid) begin
            fails++;
            $display("FAIL R8 extra response: actual 1 expected 0");
         end
      end
      check("R8", "no extra reads", nreads, 32'd2);

      finish_run();
   end

endmodule